// File: doc/BRIEF.md
# UART Receive Buffer with Flags and Interrupt

This block holds the characters that a UART receiver front end delivers before software reads them. Each entry is a data byte with error bits above it (framing, parity, break, overrun). A mode bit picks between a sixteen-entry circular queue and a single holding slot. Every write to the mode bit that changes its value empties the buffer.

A read strobe from the register decode removes the oldest entry. The error bits of the entry shown at that moment are copied into a status register. The block keeps full and empty flags and a receive interrupt level that follows a trigger count. A line-break event stores a marker entry whose only set bit is the break bit. Received characters that arrive when there is no room are dropped, and an overrun pulse is raised.

The register decode drives `lc_wr` and `lc_fifo_en` on a write to line control, and `rd_strobe` on a read of the data register. It returns `rd_entry` and `rx_status` to software.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the buffer is empty (`flag_empty`=1, `flag_full`=0), `rx_irq`=0, `rx_overrun`=0, `rx_status`=0, and the single-slot mode is active.
- R2: With `lc_fifo_en`=1 written, up to 16 entries are held and read back in arrival order; `flag_full` rises on the cycle after the sixteenth entry is stored.
- R3: In single-slot mode one entry fills the buffer and sets `flag_full`. A further push while it is occupied is dropped, and `rx_overrun` is high for exactly one cycle.
- R4: In queue mode a push while 16 entries are held is dropped, `rx_overrun` pulses, and the stored contents and their order are unchanged.
- R5: A line-control write whose mode value differs from the current mode flushes the buffer on that edge: empty set, full and `rx_irq` cleared, and new data goes to the first slot. A write with an unchanged mode value has no effect.
- R6: A cycle with `rx_break`=1 stores the value 0x400 (bit 10, the break bit, set; data byte zero). It takes precedence over `rx_valid` in the same cycle, and only one entry is stored.
- R7: `rd_entry` always shows the oldest entry. A `rd_strobe` removes that entry, but only if one is held, and latches bits 11:8 of the shown entry into `rx_status` (bit 0 framing, 1 parity, 2 break, 3 overrun). A read of an empty buffer leaves the flags unchanged.
- R8: `flag_empty` is cleared by a stored push and set when a read removes the last entry.
- R9: `rx_irq` rises when a push brings the held count to the trigger level (default 1). It falls when a read brings the count to one below that level.
- R10: A push and a read in the same cycle are both carried out when there is room, so the held count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received character present this cycle |
| rx_entry | input | 12 | Received character: data [7:0], error bits [11:8] |
| rx_break | input | 1 | Line break detected; store the break marker |
| lc_wr | input | 1 | Write to line control this cycle |
| lc_fifo_en | input | 1 | Written mode value: 1 queue, 0 single slot |
| rd_strobe | input | 1 | Data-register read this cycle |
| rd_entry | output | 12 | Oldest held entry |
| rx_status | output | 4 | Error bits latched on the last read |
| flag_full | output | 1 | No room for another entry |
| flag_empty | output | 1 | No entry held |
| rx_irq | output | 1 | Receive interrupt level |
| rx_overrun | output | 1 | One-cycle pulse for a dropped push |

## Verification
A wrong read position or count shows up at `rd_entry` at once: an entry appears out of order, or a stale slot shows after a flush. A wrong count also shows up in the flags and in `rx_irq` on the cycle after the push or read that should have moved them. Overflow handling is visible in the cycle after the rejected push, through `rx_overrun`, and again when the queue is drained and the contents are compared. Invariants that tie the flags and the interrupt level to the internal count catch a drift between them on the first cycle it occurs.

// File: rtl/rx_buf_pkg.sv
package rx_buf_pkg;
   // Position of each error flag above the data byte
   localparam int ERR_FRAME_BIT  = 0;
   localparam int ERR_PARITY_BIT = 1;
   localparam int ERR_BREAK_BIT  = 2;
   localparam int ERR_OVR_BIT    = 3;

   localparam int DEF_DATA_W = 8;
   localparam int DEF_ERR_W  = 4;
   localparam int DEF_DEPTH  = 16;
   localparam int DEF_TRIG   = 1;
endpackage

// File: rtl/rx_buf_store.sv
module rx_buf_store #(
   parameter int DEPTH   = 16,
   parameter int ENTRY_W = 12,
   localparam int PTR_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [PTR_W-1:0]   wr_ptr,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [PTR_W-1:0]   rd_ptr,
   output logic [ENTRY_W-1:0] rd_data
);
   logic [ENTRY_W-1:0] slot_q [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[gi] <= '0;
         else if (wr_en && (wr_ptr == PTR_W'(gi)))
            slot_q[gi] <= wr_data;
      end
   end

   assign rd_data = slot_q[rd_ptr];
endmodule

// File: rtl/rx_buf_ctrl.sv
module rx_buf_ctrl #(
   parameter int DEPTH    = 16,
   parameter int TRIG_LVL = 1,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic             pop_req,
   input  logic             mode_wr,
   input  logic             mode_val,
   output logic [CNT_W-1:0] cnt,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W-1:0] wr_ptr,
   output logic             push_ok,
   output logic             pop_take,
   output logic             fifo_mode,
   output logic             full,
   output logic             empty,
   output logic             irq,
   output logic             overrun
);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CNT_TRIG = CNT_W'(TRIG_LVL);
   localparam logic [CNT_W-1:0] CNT_LOW  = CNT_W'(TRIG_LVL - 1);

   logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_nxt;
   logic [PTR_W-1:0] rd_q;
   logic             mode_q, full_q, empty_q, irq_q, ovr_q;
   logic             flush, room, pop_adv;

   assign flush    = mode_wr && (mode_val != mode_q);
   assign room     = mode_q ? (cnt_q < CNT_MAX) : (cnt_q == '0);
   assign push_ok  = push_req && room && !flush;
   assign pop_take = pop_req && !flush;
   assign pop_adv  = pop_take && (cnt_q != '0);
   // A read is applied before a push of the same cycle
   assign cnt_mid  = cnt_q - CNT_W'(pop_adv);
   assign cnt_nxt  = cnt_mid + CNT_W'(push_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         rd_q    <= '0;
         mode_q  <= 1'b0;
         full_q  <= 1'b0;
         empty_q <= 1'b1;
         irq_q   <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         ovr_q <= push_req && !room && !flush;
         if (mode_wr)
            mode_q <= mode_val;
         if (flush) begin
            cnt_q   <= '0;
            rd_q    <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
            irq_q   <= 1'b0;
         end else begin
            cnt_q <= cnt_nxt;
            if (pop_adv)
               rd_q <= rd_q + PTR_W'(1);
            if (push_ok)
               full_q <= !mode_q || (cnt_nxt == CNT_MAX);
            else if (pop_take)
               full_q <= 1'b0;
            if (push_ok)
               empty_q <= 1'b0;
            else if (pop_take && (cnt_mid == '0))
               empty_q <= 1'b1;
            if (push_ok && (cnt_nxt == CNT_TRIG))
               irq_q <= 1'b1;
            else if (pop_take && (cnt_mid == CNT_LOW))
               irq_q <= 1'b0;
         end
      end
   end

   assign cnt       = cnt_q;
   assign rd_ptr    = rd_q;
   assign wr_ptr    = rd_q + cnt_q[PTR_W-1:0];
   assign fifo_mode = mode_q;
   assign full      = full_q;
   assign empty     = empty_q;
   assign irq       = irq_q;
   assign overrun   = ovr_q;
endmodule

// File: rtl/rx_buf_status.sv
module rx_buf_status #(
   parameter int ERR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [ERR_W-1:0] err_in,
   output logic [ERR_W-1:0] status
);
   logic [ERR_W-1:0] stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= '0;
      else if (cap_en)
         stat_q <= err_in;
   end

   assign status = stat_q;
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
   parameter int DATA_W   = rx_buf_pkg::DEF_DATA_W,
   parameter int ERR_W    = rx_buf_pkg::DEF_ERR_W,
   parameter int DEPTH    = rx_buf_pkg::DEF_DEPTH,
   parameter int TRIG_LVL = rx_buf_pkg::DEF_TRIG,
   localparam int ENTRY_W = DATA_W + ERR_W,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   input  logic [ENTRY_W-1:0] rx_entry,
   input  logic               rx_break,
   input  logic               lc_wr,
   input  logic               lc_fifo_en,
   input  logic               rd_strobe,
   output logic [ENTRY_W-1:0] rd_entry,
   output logic [ERR_W-1:0]   rx_status,
   output logic               flag_full,
   output logic               flag_empty,
   output logic               rx_irq,
   output logic               rx_overrun
);
   localparam logic [ENTRY_W-1:0] BREAK_MARK =
      ENTRY_W'(1) << (DATA_W + rx_buf_pkg::ERR_BREAK_BIT);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (TRIG_LVL < 1 || TRIG_LVL > DEPTH) begin : g_bad_trig
      $error("TRIG_LVL must lie in 1..DEPTH");
   end
   if (ERR_W <= rx_buf_pkg::ERR_BREAK_BIT) begin : g_bad_err
      $error("ERR_W too narrow for the break bit");
   end

   logic [CNT_W-1:0]   cnt_w;
   logic [PTR_W-1:0]   rd_ptr_w, wr_ptr_w;
   logic               push_req, push_ok, pop_take, mode_w;
   logic [ENTRY_W-1:0] push_val;

   assign push_req = rx_valid || rx_break;
   assign push_val = rx_break ? BREAK_MARK : rx_entry;

   rx_buf_ctrl #(.DEPTH(DEPTH), .TRIG_LVL(TRIG_LVL)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (push_req),
      .pop_req   (rd_strobe),
      .mode_wr   (lc_wr),
      .mode_val  (lc_fifo_en),
      .cnt       (cnt_w),
      .rd_ptr    (rd_ptr_w),
      .wr_ptr    (wr_ptr_w),
      .push_ok   (push_ok),
      .pop_take  (pop_take),
      .fifo_mode (mode_w),
      .full      (flag_full),
      .empty     (flag_empty),
      .irq       (rx_irq),
      .overrun   (rx_overrun)
   );

   rx_buf_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_ok),
      .wr_ptr  (wr_ptr_w),
      .wr_data (push_val),
      .rd_ptr  (rd_ptr_w),
      .rd_data (rd_entry)
   );

   rx_buf_status #(.ERR_W(ERR_W)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (pop_take),
      .err_in (rd_entry[ENTRY_W-1:DATA_W]),
      .status (rx_status)
   );
endmodule

// File: rtl/rx_buf_chk.sv
module rx_buf_chk #(
   parameter int DEPTH    = 16,
   parameter int TRIG_LVL = 1,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             rx_break,
   input logic             lc_wr,
   input logic             lc_fifo_en,
   input logic             rd_strobe,
   input logic             flag_full,
   input logic             flag_empty,
   input logic             rx_irq,
   input logic             rx_overrun,
   input logic [CNT_W-1:0] cnt,
   input logic [PTR_W-1:0] rd_ptr,
   input logic             fifo_mode
);
   logic flush_c, push_c;
   assign flush_c = lc_wr && (lc_fifo_en != fifo_mode);
   assign push_c  = (rx_valid || rx_break) && !flag_full && !flush_c;

   // R8: empty flag agrees with the held count
   a_r8_empty_match: assert property (@(posedge clk) disable iff (!rst_n)
      flag_empty == (cnt == '0));

   // R2 / R3: full flag agrees with the count for the active mode
   a_r2_full_match: assert property (@(posedge clk) disable iff (!rst_n)
      flag_full == (fifo_mode ? (cnt == CNT_W'(DEPTH)) : (cnt != '0)));

   // R4: the count never exceeds the storage
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   // R3: an overrun pulse follows only a cycle with no room
   a_r3_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> $past(flag_full));

   // R9: interrupt level follows the count against the trigger
   a_r9_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq == (cnt >= CNT_W'(TRIG_LVL)));

   // R5: a mode change empties the buffer and rewinds the read position
   a_r5_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush_c |=> (cnt == '0) && (rd_ptr == '0));

   // R10: a stored push with a read of a non-empty buffer keeps the count
   a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (push_c && rd_strobe && (cnt != '0)) |=> (cnt == $past(cnt)));
endmodule

bind uart_rx_buffer rx_buf_chk #(.DEPTH(DEPTH), .TRIG_LVL(TRIG_LVL)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .rx_break   (rx_break),
   .lc_wr      (lc_wr),
   .lc_fifo_en (lc_fifo_en),
   .rd_strobe  (rd_strobe),
   .flag_full  (flag_full),
   .flag_empty (flag_empty),
   .rx_irq     (rx_irq),
   .rx_overrun (rx_overrun),
   .cnt        (cnt_w),
   .rd_ptr     (rd_ptr_w),
   .fifo_mode  (mode_w)
);

// File: tb/test_uart_rx_buffer.sv
`timescale 1ns/1ps
module test_uart_rx_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [11:0] rx_entry = '0;
   logic        rx_break = 1'b0;
   logic        lc_wr = 1'b0;
   logic        lc_fifo_en = 1'b0;
   logic        rd_strobe = 1'b0;
   logic [11:0] rd_entry;
   logic [3:0]  rx_status;
   logic        flag_full, flag_empty, rx_irq, rx_overrun;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   uart_rx_buffer i_uart_rx_buffer (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_entry(rx_entry),
      .rx_break(rx_break), .lc_wr(lc_wr), .lc_fifo_en(lc_fifo_en),
      .rd_strobe(rd_strobe), .rd_entry(rd_entry), .rx_status(rx_status),
      .flag_full(flag_full), .flag_empty(flag_empty), .rx_irq(rx_irq),
      .rx_overrun(rx_overrun)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [11:0] v);
      rx_valid = 1'b1; rx_entry = v;
      step();
      rx_valid = 1'b0;
   endtask

   task automatic set_mode(input logic m);
      lc_wr = 1'b1; lc_fifo_en = m;
      step();
      lc_wr = 1'b0;
   endtask

   task automatic pop_expect(input string req, input logic [11:0] exp);
      chk({req, " rd_entry"}, 32'(rd_entry), 32'(exp));
      rd_strobe = 1'b1;
      step();
      rd_strobe = 1'b0;
      chk({req, " rx_status"}, 32'(rx_status), 32'(exp[11:8]));
   endtask

   task automatic t_reset();
      chk("R1 empty", 32'(flag_empty), 1);
      chk("R1 full", 32'(flag_full), 0);
      chk("R1 irq", 32'(rx_irq), 0);
      chk("R1 overrun", 32'(rx_overrun), 0);
      chk("R1 status", 32'(rx_status), 0);
   endtask

   task automatic t_single();
      push(12'h0A5);
      chk("R8 empty cleared", 32'(flag_empty), 0);
      chk("R3 full single", 32'(flag_full), 1);
      chk("R9 irq set", 32'(rx_irq), 1);
      push(12'h05A);
      chk("R3 overrun pulse", 32'(rx_overrun), 1);
      step();
      chk("R3 overrun one cycle", 32'(rx_overrun), 0);
      pop_expect("R3 kept first", 12'h0A5);
      chk("R8 empty after drain", 32'(flag_empty), 1);
      chk("R3 full cleared", 32'(flag_full), 0);
      chk("R9 irq cleared", 32'(rx_irq), 0);
   endtask

   task automatic t_fifo();
      set_mode(1'b1);
      for (int i = 0; i < 16; i++) begin
         push(12'((i % 4) * 256 + i * 3 + 1));
         if (i == 14) chk("R2 not full at 15", 32'(flag_full), 0);
      end
      chk("R2 full at 16", 32'(flag_full), 1);
      push(12'h0EE);
      chk("R4 overrun when full", 32'(rx_overrun), 1);
      for (int i = 0; i < 16; i++)
         pop_expect("R2 R4 order", 12'((i % 4) * 256 + i * 3 + 1));
      chk("R8 empty after queue drain", 32'(flag_empty), 1);
      chk("R9 irq low after drain", 32'(rx_irq), 0);
   endtask

   task automatic t_break();
      rx_break = 1'b1; rx_valid = 1'b1; rx_entry = 12'h033;
      step();
      rx_break = 1'b0; rx_valid = 1'b0;
      pop_expect("R6 break marker", 12'h400);
      chk("R6 single entry", 32'(flag_empty), 1);
   endtask

   task automatic t_simul();
      push(12'h111);
      rx_valid = 1'b1; rx_entry = 12'h222; rd_strobe = 1'b1;
      step();
      rx_valid = 1'b0; rd_strobe = 1'b0;
      chk("R10 status of popped", 32'(rx_status), 1);
      chk("R10 not empty", 32'(flag_empty), 0);
      chk("R10 irq held", 32'(rx_irq), 1);
      pop_expect("R10 second stored", 12'h222);
      chk("R10 count was one", 32'(flag_empty), 1);
   endtask

   task automatic t_flush();
      push(12'h301); push(12'h302); push(12'h303);
      set_mode(1'b1);
      chk("R5 same mode keeps data", 32'(rd_entry), 12'h301);
      chk("R5 same mode not empty", 32'(flag_empty), 0);
      set_mode(1'b0);
      chk("R5 flush empty", 32'(flag_empty), 1);
      chk("R5 flush full", 32'(flag_full), 0);
      chk("R5 flush irq", 32'(rx_irq), 0);
      push(12'h0C3);
      chk("R5 new data first slot", 32'(rd_entry), 12'h0C3);
      chk("R5 single mode after flush", 32'(flag_full), 1);
      pop_expect("R5 drain", 12'h0C3);
   endtask

   task automatic t_empty_read();
      rd_strobe = 1'b1;
      step();
      rd_strobe = 1'b0;
      chk("R7 empty read empty", 32'(flag_empty), 1);
      chk("R7 empty read full", 32'(flag_full), 0);
      chk("R7 empty read irq", 32'(rx_irq), 0);
      push(12'h0AB);
      pop_expect("R7 after empty read", 12'h0AB);
   endtask

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_single();
      t_fifo();
      t_break();
      t_simul();
      t_flush();
      t_empty_read();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule